// File: doc/BRIEF.md
# Sticky Status Interrupt and Trigger Controller

This block sits on a narrow 4-bit processor register bus. Six error event inputs from the link datapaths come in as one-cycle pulses or as levels. The block latches each of them into a sticky status bit, and that bit stays set until software clears its group. Four bits belong to the link-to-processor direction and two to the processor-to-link direction, and each group has its own clear bit.

The block produces two active-low interrupt lines. The first line is asserted when any sticky bit and its mask bit are both set, or when an enabled trigger input is active. The second line responds only to the trigger inputs. The two trigger inputs are synchronised with two flops and then given a selectable polarity. The two trigger pins can also be driven as outputs. Each then carries the first interrupt condition, with its own polarity bit, so software can produce a trigger pulse by toggling that polarity bit. Every pin has an output-enable that is held low (high-Z) until software sets it.

Top module: `irq_trig_ctrl`

## Requirements
- R1: A synchronous reset clears every control register. After reset, irq1_n and irq2_n are 1 and all output enables and trigger outputs are 0.
- R2: Control registers at addresses 0x00–0x07 are written when bus_wr is high. The registered read data for the address presented appears on bus_rdata one cycle later. Unused bits read as 0: address 0x01 bit 3, address 0x02 bit 3, and address 0x07 bits 3:2.
- R3: Address 0x20 returns the link-side sticky bits, with bit n taken from ev_l2p[n]. Address 0x21 returns the two host-side sticky bits from ev_p2l[1:0] in bits 1:0, with bits 3:2 reading 0. Writes to these addresses have no effect, and all other addresses read 0.
- R4: An event that is high for a single clock sets its sticky bit on that edge. The bit then stays 1 without further events.
- R5: Address 0x02 bit 0 clears only the 0x20 group, and bit 1 clears only the 0x21 group. Clearing is level-sensitive. While a clear bit is held at 1, events in its group are ignored.
- R6: Address 0x06 bit n enables 0x20 sticky bit n onto IRQ1, and address 0x07 bits 1:0 enable the 0x21 sticky bits onto IRQ1. irq1_n goes low on the clock edge after a sticky bit is set whose mask bit is 1.
- R7: Each trigger input passes through two synchroniser flops and is then XORed with its inversion bit: address 0x04 bit 0 for input A (trig_in[0]) and bit 1 for input B. Address 0x05 bits 0/1 route A/B into IRQ1, and bits 2/3 route A/B into IRQ2. An input change reaches the interrupt line after three clock edges.
- R8: Address 0x03 bit 0 enables irq1_oe, bit 1 enables irq2_oe, bit 2 enables trig_oe[0] and bit 3 enables trig_oe[1]. Each output-enable follows its bit one cycle after the register write.
- R9: trig_out[k] equals the active-high IRQ1 condition XORed with its output inversion bit, address 0x04 bit 2+k. Toggling that bit while the condition is steady toggles the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data for bus_addr |
| ev_l2p | input | 4 | Link-to-processor error events |
| ev_p2l | input | 2 | Processor-to-link error events |
| trig_in | input | 2 | Trigger pin input levels (0 = A, 1 = B) |
| trig_out | output | 2 | Trigger pin output levels |
| trig_oe | output | 2 | Trigger pin output enables |
| irq1_n | output | 1 | Interrupt 1, active low |
| irq1_oe | output | 1 | Interrupt 1 output enable |
| irq2_n | output | 1 | Interrupt 2, active low |
| irq2_oe | output | 1 | Interrupt 2 output enable |

## Verification
A sticky bit that is lost or set wrongly shows up on the next read of 0x20 or 0x21. When its mask is on, the fault also reaches irq1_n and trig_out one edge after the event. A faulty synchroniser chain or a faulty polarity stage moves the interrupt edge away from the third edge after an input change, or inverts it, so latency is checked exactly once and levels are checked by sweeps. Faulty clear-group decoding is detected by clearing one group and reading the other group back.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int DW    = 4;
  localparam int AW    = 6;
  localparam int NCTRL = 8;
  localparam logic [AW-1:0] STAT0_ADDR = 6'h20;
  localparam logic [AW-1:0] STAT1_ADDR = 6'h21;

  // control register indices
  localparam int C_PORT = 0;
  localparam int C_RST  = 1;
  localparam int C_CLR  = 2;
  localparam int C_OE   = 3;
  localparam int C_POL  = 4;
  localparam int C_TRG  = 5;
  localparam int C_MSK0 = 6;
  localparam int C_MSK1 = 7;

  // storage mask: bits that exist in each control register
  function automatic logic [DW-1:0] ctrl_keep(input int idx);
    case (idx)
      C_RST, C_CLR: return 4'h7;
      C_MSK1:       return 4'h3;
      default:      return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/itc_ctrl_regs.sv
module itc_ctrl_regs
  import itc_pkg::*;
#(
  parameter int W  = DW,
  parameter int A  = AW,
  parameter int N  = NCTRL
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [A-1:0]   addr,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] regs_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr && addr == A'(g)) q <= wdata & W'(ctrl_keep(g));
    end
    assign regs_flat[g*W +: W] = q;
  end
endmodule

// File: rtl/itc_sticky.sv
module itc_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] ev,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) q[g] <= 1'b0;
      else if (ev[g]) q[g] <= 1'b1;
    end

    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
      (ev[g] && !clr) |=> q[g]);
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (q[g] && !clr) |=> q[g]);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
      clr |=> !q[g]);
  end
endmodule

// File: rtl/itc_sync.sv
module itc_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[g]};
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
  import itc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    ev_l2p,
  input  logic [1:0]    ev_p2l,
  input  logic [1:0]    trig_in,
  output logic [1:0]    trig_out,
  output logic [1:0]    trig_oe,
  output logic          irq1_n,
  output logic          irq1_oe,
  output logic          irq2_n,
  output logic          irq2_oe
);
  logic [NCTRL*DW-1:0] regs_flat;
  logic [DW-1:0]       ctrl [NCTRL];
  logic [3:0]          stk0;
  logic [1:0]          stk1;
  logic [1:0]          trig_sync, trig_act;
  logic                irq1_cond, irq2_cond;

  itc_ctrl_regs #(.W(DW), .A(AW), .N(NCTRL)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .regs_flat(regs_flat)
  );

  for (genvar g = 0; g < NCTRL; g++) begin : g_unpack
    assign ctrl[g] = regs_flat[g*DW +: DW];
  end

  itc_sticky #(.W(4)) u_stk0 (
    .clk(clk), .rst(rst), .clr(ctrl[C_CLR][0]), .ev(ev_l2p), .q(stk0)
  );
  itc_sticky #(.W(2)) u_stk1 (
    .clk(clk), .rst(rst), .clr(ctrl[C_CLR][1]), .ev(ev_p2l), .q(stk1)
  );

  itc_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trig_in), .q(trig_sync)
  );

  always_comb begin
    trig_act  = trig_sync ^ ctrl[C_POL][1:0];
    irq1_cond = (|(stk0 & ctrl[C_MSK0])) | (|(stk1 & ctrl[C_MSK1][1:0]))
              | (|(trig_act & ctrl[C_TRG][1:0]));
    irq2_cond = |(trig_act & ctrl[C_TRG][3:2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq1_n   <= 1'b1;
      irq2_n   <= 1'b1;
      trig_out <= '0;
      irq1_oe  <= 1'b0;
      irq2_oe  <= 1'b0;
      trig_oe  <= '0;
    end else begin
      irq1_n   <= ~irq1_cond;
      irq2_n   <= ~irq2_cond;
      trig_out <= {2{irq1_cond}} ^ ctrl[C_POL][3:2];
      irq1_oe  <= ctrl[C_OE][0];
      irq2_oe  <= ctrl[C_OE][1];
      trig_oe  <= ctrl[C_OE][3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr[AW-1:3] == '0) bus_rdata <= ctrl[bus_addr[2:0]];
    else if (bus_addr == STAT0_ADDR) bus_rdata <= stk0;
    else if (bus_addr == STAT1_ADDR) bus_rdata <= {2'b00, stk1};
    else bus_rdata <= '0;
  end

  a_r6_mask_to_irq1: assert property (@(posedge clk) disable iff (rst)
    (|(stk0 & ctrl[C_MSK0])) |=> !irq1_n);
  a_r8_trig_oe_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_OE][2] |=> !trig_oe[0]);
  a_r1_irq2_idle: assert property (@(posedge clk) disable iff (rst)
    (ctrl[C_TRG][3:2] == 2'b00) |=> irq2_n);
endmodule

// File: tb/irq_trig_ctrl_test.sv
module irq_trig_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic [5:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [3:0] bus_wdata = 0;
  logic [3:0] bus_rdata;
  logic [3:0] ev_l2p = 0;
  logic [1:0] ev_p2l = 0;
  logic [1:0] trig_in = 0;
  logic [1:0] trig_out, trig_oe;
  logic       irq1_n, irq1_oe, irq2_n, irq2_oe;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trig_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_l2p(ev_l2p),
    .ev_p2l(ev_p2l), .trig_in(trig_in), .trig_out(trig_out),
    .trig_oe(trig_oe), .irq1_n(irq1_n), .irq1_oe(irq1_oe),
    .irq2_n(irq2_n), .irq2_oe(irq2_oe)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] l, input logic [1:0] p);
    @(negedge clk); ev_l2p = l; ev_p2l = p;
    @(negedge clk); ev_l2p = 0; ev_p2l = 0;
  endtask

  task automatic clear_all();
    wr(6'h02, 4'h3); wr(6'h02, 4'h0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] r;
    logic       c1, c2;
    logic [1:0] ta;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({2'b0, irq1_n, irq2_n}, 4'h3, "R1 irq lines");
    chk({irq1_oe, irq2_oe, trig_oe}, 4'h0, "R1 enables");
    chk({2'b0, trig_out}, 4'h0, "R1 trig_out");
    for (int a = 0; a < 8; a++) begin
      rd(6'(a), r); chk(r, 4'h0, "R1 ctrl reset");
    end

    // R2 write/read sweep with unused bits
    for (int a = 0; a < 8; a++)
      for (int v = 0; v < 16; v++) begin
        logic [3:0] keep;
        keep = (a == 1 || a == 2) ? 4'h7 : (a == 7) ? 4'h3 : 4'hF;
        wr(6'(a), 4'(v)); rd(6'(a), r);
        chk(r, 4'(v) & keep, "R2 ctrl readback");
      end
    for (int a = 0; a < 8; a++) wr(6'(a), 4'h0);

    // R3 status read-only, unmapped reads 0
    pulse(4'hF, 2'h3);
    wr(6'h20, 4'h0); wr(6'h21, 4'h0);
    rd(6'h20, r); chk(r, 4'hF, "R3 status0 write ignored");
    rd(6'h21, r); chk(r, 4'h3, "R3 status1 write ignored");
    for (int a = 6'h22; a < 6'h30; a++) begin
      rd(6'(a), r); chk(r, 4'h0, "R3 unmapped reads zero");
    end
    rd(6'h08, r); chk(r, 4'h0, "R3 addr 0x08 zero");

    // R5 group separation
    wr(6'h02, 4'h1); wr(6'h02, 4'h0);
    rd(6'h20, r); chk(r, 4'h0, "R5 clr0 clears group0");
    rd(6'h21, r); chk(r, 4'h3, "R5 clr0 keeps group1");
    wr(6'h02, 4'h2); wr(6'h02, 4'h0);
    rd(6'h21, r); chk(r, 4'h0, "R5 clr1 clears group1");
    // R5 held clear ignores events
    wr(6'h06, 4'hF); wr(6'h07, 4'h3);
    wr(6'h02, 4'h3);
    pulse(4'hF, 2'h3);
    wait_n(2);
    chk({3'b0, irq1_n}, 4'h1, "R5 held clear keeps irq1 idle");
    wr(6'h02, 4'h0);
    rd(6'h20, r); chk(r, 4'h0, "R5 held clear group0");
    rd(6'h21, r); chk(r, 4'h0, "R5 held clear group1");

    // R4 single-cycle set, persistence; R6 exact latency
    wr(6'h06, 4'h4); wr(6'h07, 4'h0);
    @(negedge clk); ev_l2p = 4'h4;
    @(negedge clk); ev_l2p = 0;
    chk({3'b0, irq1_n}, 4'h1, "R6 irq1 not yet");
    @(negedge clk);
    chk({3'b0, irq1_n}, 4'h0, "R6 irq1 one edge after sticky");
    wait_n(20);
    rd(6'h20, r); chk(r, 4'h4, "R4 sticky persists");
    clear_all();
    wait_n(2);
    chk({3'b0, irq1_n}, 4'h1, "R5 irq1 released after clear");

    // R6 mask sweep, group0
    wr(6'h07, 4'h0); wr(6'h05, 4'h0);
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 16; m++) begin
        clear_all();
        wr(6'h06, 4'(m));
        pulse(4'(p), 2'h0);
        wait_n(2);
        chk({3'b0, irq1_n}, {3'b0, ~|(4'(p) & 4'(m))}, "R6 mask0 sweep");
        if (m == 0) begin rd(6'h20, r); chk(r, 4'(p), "R4 status0 pattern"); end
      end
    // R6 mask sweep, group1
    wr(6'h06, 4'h0);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++) begin
        clear_all();
        wr(6'h07, 4'(m));
        pulse(4'h0, 2'(p));
        wait_n(2);
        chk({3'b0, irq1_n}, {3'b0, ~|(2'(p) & 2'(m))}, "R6 mask1 sweep");
        rd(6'h21, r); chk(r, {2'b0, 2'(p)}, "R3 status1 pattern");
      end
    wr(6'h07, 4'h0); clear_all();

    // R7 exact synchroniser latency
    wr(6'h04, 4'h0); wr(6'h05, 4'h1);
    @(negedge clk); trig_in = 2'b01;
    wait_n(2);
    chk({3'b0, irq1_n}, 4'h1, "R7 irq1 before third edge");
    wait_n(1);
    chk({3'b0, irq1_n}, 4'h0, "R7 irq1 at third edge");
    trig_in = 0; wait_n(4);

    // R7/R9 trigger sweep
    for (int t = 0; t < 4; t++)
      for (int iv = 0; iv < 16; iv++)
        for (int m = 0; m < 16; m++) begin
          wr(6'h04, 4'(iv)); wr(6'h05, 4'(m));
          trig_in = 2'(t);
          wait_n(4);
          ta = 2'(t) ^ 2'(iv);
          c1 = |(ta & 2'(m));
          c2 = |(ta & 2'(m >> 2));
          chk({2'b0, irq1_n, irq2_n}, {2'b0, ~c1, ~c2}, "R7 trigger routing");
          chk({2'b0, trig_out}, {2'b0, {2{c1}} ^ 2'(iv >> 2)}, "R9 trigger output");
        end
    trig_in = 0; wr(6'h05, 4'h0); wr(6'h04, 4'h0); wait_n(4);

    // R9 software pulse by toggling output inversion
    chk({2'b0, trig_out}, 4'h0, "R9 idle output");
    wr(6'h04, 4'h4); wait_n(1);
    chk({2'b0, trig_out}, 4'h1, "R9 pulse rise A");
    wr(6'h04, 4'h0); wait_n(1);
    chk({2'b0, trig_out}, 4'h0, "R9 pulse fall A");

    // R8 output enables
    for (int v = 0; v < 16; v++) begin
      wr(6'h03, 4'(v)); wait_n(1);
      chk({trig_oe[1], trig_oe[0], irq2_oe, irq1_oe}, 4'(v), "R8 output enables");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule